// File: doc/BRIEF.md
# Configurable Frame Byte Extractor

This block watches a received Ethernet frame as a byte stream and picks out up to four chosen bytes into a 32-bit property word. Each of the four lanes can be switched off or pointed at one of three reference points. The first is the destination address, using a biased offset that can reach back into the preamble. The second is the end of the layer 2 header and the third is the end of the layer 3 header. The two header ends are reported by an external parser as strobes that travel alongside the bytes.

The configuration word and the FIFO-mode flag are taken on the first byte of a frame and stay fixed for that frame. One cycle after the last byte, `done` pulses. The property word and the error flag then hold their values until the next frame starts. Downstream classification logic reads `prop` when `done` is high.

Top module: `frame_byte_extract`

## Requirements
- R1: Lane n (n = 0..3) takes its 2-bit selector from `cfg[31-8n:30-8n]` and its 6-bit offset from `cfg[29-8n:24-8n]`. Its byte appears in `prop[31-8n:24-8n]`, so lane 0 is the most significant byte.
- R2: Selector 2'b00 disables the lane, and its byte reads as 8'h00 whatever its offset field holds.
- R3: Selector 2'b01 with an offset of 8 or more captures the valid byte at index (offset − 8). The byte marked by `in_sof` is index 0. Cycles with `in_valid` low neither count nor capture.
- R4: Selector 2'b01 with an offset below 8, outside FIFO mode, gives a preamble byte. Offset 7 gives 8'hD5 and offsets 0 to 6 give 8'h55.
- R5: In FIFO mode (`fifo_mode`=1), selector 2'b01 with an offset below 8 leaves the lane at 8'h00 and sets `err` for that frame.
- R6: Selector 2'b10 captures the byte that lies offset bytes after the byte that carried `l2_end`. Offset 0 is the next valid byte. A strobe counts only on a cycle with `in_valid` high.
- R7: Selector 2'b11 behaves the same way, counted from the byte that carried `l3_end`.
- R8: If the frame ends before a lane's target byte arrives, or its header strobe never comes, the lane reads 8'h00.
- R9: `done` is high for exactly the one cycle after the byte marked by `in_eof`. `prop` and `err` then hold, even if valid bytes without `in_sof` arrive between frames.
- R10: `cfg` and `fifo_mode` are sampled on the `in_sof` byte. Changes to them later in the frame have no effect on that frame.
- R11: Each new frame starts from a cleared property word and a cleared `err`. Nothing carries over from the previous frame.
- R12: After reset, `prop` is zero and `done` and `err` are low.
- R13: A frame of a single byte (`in_sof` and `in_eof` together) is handled completely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg | input | 32 | Lane selectors and offsets, sampled at frame start |
| fifo_mode | input | 1 | FIFO mode flag, sampled at frame start |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of the frame (destination address byte 0) |
| in_eof | input | 1 | Last byte of the frame |
| l2_end | input | 1 | Current byte is the last byte of the layer 2 header |
| l3_end | input | 1 | Current byte is the last byte of the layer 3 header |
| prop | output | 32 | Extracted property word |
| done | output | 1 | One-cycle pulse after the last byte |
| err | output | 1 | Reserved offset was used in FIFO mode |

## Verification
The assertions check four things on every cycle:
- a disabled lane stays zero;
- an error bit always belongs to a FIFO-mode lane with a short offset and a zero byte;
- the sampled lane configuration only changes on a start byte;
- `done` only follows an accepted end byte, and the property word only moves on accepted bytes.

Some results can only be shown by the bench scenarios. These are:
- which byte lands in which lane for each reference;
- the preamble values;
- strobe counting across gaps;
- the zero result when the target lies beyond the end of the frame;
- the clearing between frames.

// File: rtl/bx_pkg.sv
// Package: shared types and constants for the frame byte extractor.
// Assumes the preamble ahead of the destination address is seven 0x55
// bytes followed by one 0xD5 start delimiter.
package bx_pkg;

    typedef enum logic [1:0] {
        REF_NONE = 2'b00,
        REF_DA   = 2'b01,
        REF_L2   = 2'b10,
        REF_L3   = 2'b11
    } ref_e;

    localparam int unsigned LANE_BITS = 8;
    localparam int unsigned OFF_W     = 6;
    localparam int unsigned DA_BIAS   = 8;
    localparam logic [7:0]  PRE_FILL  = 8'h55;
    localparam logic [7:0]  PRE_SFD   = 8'hD5;

    // Byte of the preamble selected by a biased offset below DA_BIAS.
    function automatic logic [7:0] preamble_byte(input logic [OFF_W-1:0] off);
        return (off == OFF_W'(DA_BIAS - 1)) ? PRE_SFD : PRE_FILL;
    endfunction

endpackage

// File: rtl/bx_pos_track.sv
// Position tracker: reports the index of the current byte from the start
// of the destination address, and from the byte after each header-end strobe.
// Assumes take is high only for accepted bytes of a frame; counters saturate.
module bx_pos_track #(
    parameter int unsigned POS_W = 7,
    parameter int unsigned HDRS  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       take,
    input  logic                       sof,
    input  logic [HDRS-1:0]            hdr_end,
    output logic [POS_W-1:0]           da_pos,
    output logic [HDRS-1:0][POS_W-1:0] hdr_pos,
    output logic [HDRS-1:0]            hdr_ok
);
    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic [POS_W-1:0] da_cnt;

    // Current index from the destination address; the start byte is index 0.
    always_comb da_pos = sof ? '0 : da_cnt;

    // Advance the address-relative index on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            da_cnt <= '0;
        else if (take)
            da_cnt <= (da_pos == POS_MAX) ? POS_MAX : da_pos + 1'b1;
    end

    for (genvar h = 0; h < HDRS; h++) begin : g_hdr
        logic [POS_W-1:0] cnt;
        logic             arm;

        // A count is valid only after its strobe, and never on a start byte.
        always_comb begin
            hdr_ok[h]  = arm && !sof;
            hdr_pos[h] = cnt;
        end

        // Arm on the strobe byte; count the bytes that follow it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                arm <= 1'b0;
                cnt <= '0;
            end else if (take) begin
                if (hdr_end[h]) begin
                    arm <= 1'b1;
                    cnt <= '0;
                end else if (sof) begin
                    arm <= 1'b0;
                end else if (arm && cnt != POS_MAX) begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bx_lane.sv
// Lane picker: holds one lane's selector, offset and FIFO flag, sampled at
// frame start, and captures the first byte whose position matches.
// Assumes positions come from bx_pos_track for the same accepted bytes.
module bx_lane
    import bx_pkg::*;
#(
    parameter int unsigned POS_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    take,
    input  logic                    sof,
    input  logic                    fifo_in,
    input  logic [LANE_BITS-1:0]    cfg_in,
    input  logic [7:0]              data,
    input  logic [POS_W-1:0]        da_pos,
    input  logic [1:0][POS_W-1:0]   hdr_pos,
    input  logic [1:0]              hdr_ok,
    output logic [7:0]              byte_q,
    output logic                    err_q
);
    localparam logic [POS_W-1:0] BIAS = POS_W'(DA_BIAS);

    ref_e             ctl_r, ctl;
    logic [OFF_W-1:0] off_r, off;
    logic             fifo_r, got_r, got, hit, short_off;
    logic [POS_W-1:0] off_x;

    // Settings in force for this byte: fresh on the start byte, else sampled.
    always_comb begin
        ctl       = sof ? ref_e'(cfg_in[7:6]) : ctl_r;
        off       = sof ? cfg_in[5:0] : off_r;
        got       = sof ? 1'b0 : got_r;
        off_x     = {{(POS_W-OFF_W){1'b0}}, off};
        short_off = off < OFF_W'(DA_BIAS);
    end

    // Decide whether the current byte is this lane's target.
    always_comb begin
        case (ctl)
            REF_DA:  hit = !short_off && (da_pos == off_x - BIAS);
            REF_L2:  hit = hdr_ok[0] && (hdr_pos[0] == off_x);
            REF_L3:  hit = hdr_ok[1] && (hdr_pos[1] == off_x);
            default: hit = 1'b0;
        endcase
    end

    // Sample settings at frame start and capture the first matching byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_r  <= REF_NONE;
            off_r  <= '0;
            fifo_r <= 1'b0;
            got_r  <= 1'b0;
            byte_q <= '0;
            err_q  <= 1'b0;
        end else if (take) begin
            if (sof) begin
                ctl_r  <= ctl;
                off_r  <= off;
                fifo_r <= fifo_in;
                got_r  <= 1'b0;
                byte_q <= '0;
                err_q  <= 1'b0;
                if (ctl == REF_DA && short_off) begin
                    if (fifo_in) begin
                        err_q <= 1'b1;
                    end else begin
                        byte_q <= preamble_byte(off);
                        got_r  <= 1'b1;
                    end
                end
            end
            if (hit && !got) begin
                byte_q <= data;
                got_r  <= 1'b1;
            end
        end
    end

    // A disabled lane never holds a nonzero byte.
    assert_idle_lane_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_r == REF_NONE) |-> (byte_q == 8'h00));

    // An error belongs only to a FIFO-mode lane with a short biased offset.
    assert_fifo_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (fifo_r && ctl_r == REF_DA && off_r < OFF_W'(DA_BIAS) && byte_q == 8'h00));

    // Sampled settings change only on an accepted start byte.
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && sof) |=> $stable({ctl_r, off_r, fifo_r}));
endmodule

// File: rtl/frame_byte_extract.sv
// Top: extracts up to four configurable bytes of a received frame into a
// 32-bit property word and pulses done after the last byte.
// Assumes header-end strobes are aligned to the last byte of their header.
module frame_byte_extract
    import bx_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned POS_W = 7,
    localparam int unsigned CFG_W = LANES * LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    input  logic             fifo_mode,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    input  logic             l2_end,
    input  logic             l3_end,
    output logic [CFG_W-1:0] prop,
    output logic             done,
    output logic             err
);
    logic                   in_frame, take;
    logic [POS_W-1:0]       da_pos;
    logic [1:0][POS_W-1:0]  hdr_pos;
    logic [1:0]             hdr_ok;
    logic [LANES-1:0]       lane_err;

    // A byte is accepted if it starts a frame or lies inside one.
    always_comb take = in_valid && (in_sof || in_frame);

    // Track frame membership and raise done after the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= take && in_eof;
            if (take)
                in_frame <= !in_eof;
        end
    end

    bx_pos_track #(.POS_W(POS_W), .HDRS(2)) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .sof     (in_sof),
        .hdr_end ({l3_end, l2_end}),
        .da_pos  (da_pos),
        .hdr_pos (hdr_pos),
        .hdr_ok  (hdr_ok)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        bx_lane #(.POS_W(POS_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .take    (take),
            .sof     (in_sof),
            .fifo_in (fifo_mode),
            .cfg_in  (cfg[CFG_W-1-LANE_BITS*n -: LANE_BITS]),
            .data    (in_data),
            .da_pos  (da_pos),
            .hdr_pos (hdr_pos),
            .hdr_ok  (hdr_ok),
            .byte_q  (prop[CFG_W-1-LANE_BITS*n -: LANE_BITS]),
            .err_q   (lane_err[n])
        );
    end

    // The frame error is any lane's error.
    always_comb err = |lane_err;

    // done only follows an accepted end byte.
    assert_done_after_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(take && in_eof));

    // The property word moves only on accepted bytes.
    assert_prop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(take) |-> $stable(prop));
endmodule

// File: tb/sim_frame_byte_extract.sv
`timescale 1ns/1ps
module sim_frame_byte_extract;
    typedef struct {
        logic [31:0] p;
        logic        e;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg = '0;
    logic        fifo_mode = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        l2_end = 1'b0;
    logic        l3_end = 1'b0;
    logic [31:0] prop;
    logic        done;
    logic        err;

    int   total = 0;
    int   bad = 0;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    frame_byte_extract u0 (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .fifo_mode(fifo_mode),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .l2_end(l2_end), .l3_end(l3_end), .prop(prop), .done(done), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int i, input int seed);
        return 8'((i * 37) + (seed * 11) + 1);
    endfunction

    // Lane packing: lane0 in the top byte, selector above offset (R1).
    function automatic logic [31:0] mk(input logic [1:0] c0, input logic [5:0] o0,
                                       input logic [1:0] c1, input logic [5:0] o1,
                                       input logic [1:0] c2, input logic [5:0] o2,
                                       input logic [1:0] c3, input logic [5:0] o3);
        return {c0, o0, c1, o1, c2, o2, c3, o3};
    endfunction

    // Reference model of one frame's result, built from the requirements.
    function automatic exp_t model(input int len, input logic [31:0] c, input logic f,
                                   input int l2p, input int l3p, input int seed, input string req);
        exp_t r;
        r.p = '0;
        r.e = 1'b0;
        r.req = req;
        for (int n = 0; n < 4; n++) begin
            logic [1:0] ctl;
            int off, idx;
            logic [7:0] b;
            ctl = c[31-8*n -: 2];
            off = int'(c[29-8*n -: 6]);
            b = 8'h00;
            case (ctl)
                2'b01: begin
                    if (off >= 8) begin
                        if (off - 8 < len) b = dbyte(off - 8, seed);
                    end else if (f) begin
                        r.e = 1'b1;
                    end else begin
                        b = (off == 7) ? 8'hD5 : 8'h55;
                    end
                end
                2'b10, 2'b11: begin
                    idx = ((ctl == 2'b10) ? l2p : l3p);
                    if (idx >= 0 && idx + 1 + off < len) b = dbyte(idx + 1 + off, seed);
                end
                default: b = 8'h00;
            endcase
            r.p[31-8*n -: 8] = b;
        end
        return r;
    endfunction

    // Driver: pushes the expected result, then plays the frame with gaps.
    task automatic run_frame(input int len, input logic [31:0] c, input logic f,
                             input int l2p, input int l3p,
                             input logic [31:0] c_mid, input logic f_mid,
                             input int seed, input string req);
        exp_t r;
        r = model(len, c, f, l2p, l3p, seed, req);
        exp_q.push_back(r);
        for (int i = 0; i < len; i++) begin
            if (i % 4 == 3) begin
                // Invalid cycle with noisy strobes and data: must be ignored (R3, R6).
                @(negedge clk);
                in_valid = 1'b0; in_data = 8'hEE; in_sof = 1'b0;
                in_eof = 1'b1; l2_end = 1'b1; l3_end = 1'b1;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = dbyte(i, seed);
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            l2_end   = (i == l2p);
            l3_end   = (i == l3p);
            cfg       = (i == 0) ? c : c_mid;
            fifo_mode = (i == 0) ? f : f_mid;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; l2_end = 1'b0; l3_end = 1'b0;
        @(negedge clk);
        check("R9 done width", {31'd0, done}, 32'd0);
        check({req, " R9 held"}, prop, r.p);
        // Valid bytes outside a frame must not disturb the result (R9).
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'hA5; l2_end = 1'b1; l3_end = 1'b1;
            in_eof = (k == 2); cfg = 32'h4848_4848;
        end
        @(negedge clk);
        in_valid = 1'b0; l2_end = 1'b0; l3_end = 1'b0; in_eof = 1'b0;
        @(negedge clk);
        check("R9 outside bytes", prop, r.p);
        check("R9 err held", {31'd0, err}, {31'd0, r.e});
    endtask

    // Monitor: compares each done pulse against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t r;
                r = exp_q.pop_front();
                check(r.req, prop, r.p);
                check({r.req, " err"}, {31'd0, err}, {31'd0, r.e});
            end
        end
    end

    initial begin
        #(5.0 * 100000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R12 prop", prop, 32'd0);
        check("R12 done", {31'd0, done}, 32'd0);
        check("R12 err", {31'd0, err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R3: address-relative lanes with various offsets.
        run_frame(60, mk(2'b01, 6'd8, 2'b01, 6'd9, 2'b01, 6'd20, 2'b01, 6'd63),
                  1'b0, -1, -1, '0, 1'b0, 1, "R1 R3");
        // R4: preamble bytes outside FIFO mode.
        run_frame(12, mk(2'b01, 6'd0, 2'b01, 6'd6, 2'b01, 6'd7, 2'b01, 6'd8),
                  1'b0, -1, -1, '0, 1'b0, 2, "R4");
        // R5: the same selection in FIFO mode.
        run_frame(12, mk(2'b01, 6'd0, 2'b01, 6'd6, 2'b01, 6'd7, 2'b01, 6'd8),
                  1'b1, -1, -1, '0, 1'b0, 3, "R5");
        // R6, R7: header-relative lanes.
        run_frame(64, mk(2'b10, 6'd0, 2'b10, 6'd5, 2'b11, 6'd0, 2'b11, 6'd10),
                  1'b0, 13, 33, '0, 1'b0, 4, "R6 R7");
        // R2: disabled lanes with nonzero offsets.
        run_frame(40, mk(2'b00, 6'd12, 2'b01, 6'd10, 2'b00, 6'd63, 2'b11, 6'd2),
                  1'b0, 5, 20, '0, 1'b0, 5, "R2");
        // R8: targets beyond the end, and a strobe that never comes.
        run_frame(20, mk(2'b01, 6'd40, 2'b10, 6'd0, 2'b11, 6'd10, 2'b01, 6'd27),
                  1'b0, -1, 15, '0, 1'b0, 6, "R8");
        // R10: selectors and FIFO flag change right after the start byte.
        run_frame(30, mk(2'b01, 6'd10, 2'b01, 6'd3, 2'b10, 6'd0, 2'b00, 6'd0),
                  1'b1, 7, -1, mk(2'b01, 6'd9, 2'b01, 6'd9, 2'b01, 6'd9, 2'b01, 6'd9),
                  1'b0, 7, "R10");
        // R11: a new frame with every lane disabled clears word and error.
        run_frame(16, '0, 1'b0, 2, 4, '0, 1'b0, 8, "R11");
        // R13: single-byte frame.
        run_frame(1, mk(2'b01, 6'd8, 2'b01, 6'd7, 2'b01, 6'd9, 2'b00, 6'd0),
                  1'b0, -1, -1, '0, 1'b0, 9, "R13");
        // R3: longer frame with a mid-range address offset.
        run_frame(50, mk(2'b01, 6'd50, 2'b11, 6'd1, 2'b10, 6'd3, 2'b01, 6'd31),
                  1'b0, 10, 30, '0, 1'b0, 10, "R3 mix");

        repeat (4) @(negedge clk);
        check("R9 all results seen", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule